// File: doc/BRIEF.md
# Millisecond Periodic Tick Timer

This block produces a regular one-clock pulse at a programmable whole number of milliseconds. A fixed prescaler divides the system clock into a one-millisecond strobe. With the default setting of 24 000 cycles, a 24 MHz clock gives 1 ms resolution. A second counter counts those strobes against an 8-bit period value and pulses the output each time the period runs out.

The processor sets the period by driving a byte onto its first output port and asserting a one-cycle load strobe. Each load restarts the whole time base, so the first pulse after a load falls exactly one full period later. A period of zero stops the pulses. Any value above the ceiling of 250 is clamped to 250, which keeps usable periods between 1 ms and 250 ms.

Top module: `mstick_timer`

## Requirements
- R1: After reset the output is low, and the stored period is zero (pulses off) until the first load.
- R2: Each output pulse is high for exactly one clock cycle.
- R3: With a stored period P from 1 to 250, the output is high in the cycle after clock edge L + k·P·N for every k ≥ 1. L is the edge that sampled the load strobe and N is the prescaler length. At no other time is the output high.
- R4: The prescaler marks one millisecond every N clock cycles (parameter, default 24 000). With P = 1 the pulses are exactly N cycles apart.
- R5: A stored period of 0 keeps the output low for as long as it is held.
- R6: A loaded value greater than 250 is stored as 250. Values from 0 to 250 are stored unchanged.
- R7: A load clears both the prescaler and the millisecond count. If a load arrives on the edge where a pulse would have started, that pulse is suppressed and timing restarts from the load.
- R8: The load strobe is sampled on the rising clock edge. The period data is read only on edges where the strobe is high, so changing it at other times has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (24 MHz nominal) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | One-cycle strobe that loads a new period |
| period_i | input | 8 | Period in milliseconds, from output port 0 |
| tick_o | output | 1 | One-cycle pulse at the end of each period |

## Verification
The assertions assume that the reset is released and that `period_i` is meaningful whenever `load_i` is high. They assume nothing about how often loads occur: loads may come back to back or land on the very edge where a pulse is due. The stimulus runs the prescaler at a short length so that many periods fit in the run. It draws periods mostly from 0 to 12, and sometimes from the clamp region above 250. Reloads come at random points, including during a period. The stimulus also scrambles `period_i` while the strobe is low, so the data bus is not assumed to be held steady.

// File: rtl/mstick_pkg.sv
package mstick_pkg;
   localparam int DEF_CYC_PER_MS = 24000;
   localparam int DEF_PERIOD_W   = 8;
   localparam int DEF_MAX_PERIOD = 250;
endpackage

// File: rtl/mstick_prescale.sv
module mstick_prescale #(
   parameter int CYC_PER_MS = 24000,
   localparam int CNT_W     = $clog2(CYC_PER_MS)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             restart_i,
   output logic             ms_stb_o,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC_PER_MS - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q <= '0;
      else if (restart_i)       cnt_q <= '0;
      else if (cnt_q == LAST)   cnt_q <= '0;
      else                      cnt_q <= cnt_q + 1'b1;
   end

   assign ms_stb_o = (cnt_q == LAST) && !restart_i;
   assign cnt_o    = cnt_q;
endmodule

// File: rtl/mstick_period_reg.sv
module mstick_period_reg #(
   parameter int PERIOD_W   = 8,
   parameter int MAX_PERIOD = 250,
   parameter int RST_PERIOD = 0
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                load_i,
   input  logic [PERIOD_W-1:0] din_i,
   output logic [PERIOD_W-1:0] per_o
);
   localparam int FULL = (1 << PERIOD_W) - 1;

   logic [PERIOD_W-1:0] lim_d;
   logic [PERIOD_W-1:0] per_q;

   generate
      if (MAX_PERIOD >= FULL) begin : g_noclamp
         assign lim_d = din_i;
      end else begin : g_clamp
         localparam logic [PERIOD_W-1:0] CEIL = PERIOD_W'(MAX_PERIOD);
         assign lim_d = (din_i > CEIL) ? CEIL : din_i;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      per_q <= PERIOD_W'(RST_PERIOD);
      else if (load_i)  per_q <= lim_d;
   end

   assign per_o = per_q;
endmodule

// File: rtl/mstick_ms_count.sv
module mstick_ms_count #(
   parameter int PERIOD_W = 8
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                restart_i,
   input  logic                ms_stb_i,
   input  logic [PERIOD_W-1:0] per_i,
   output logic                tick_o,
   output logic [PERIOD_W-1:0] cnt_o
);
   logic [PERIOD_W-1:0] cnt_q;
   logic                tick_q;
   logic                at_end;

   assign at_end = ({1'b0, cnt_q} + 1'b1) == {1'b0, per_i};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         tick_q <= 1'b0;
      end else if (restart_i) begin
         cnt_q  <= '0;
         tick_q <= 1'b0;
      end else if (ms_stb_i) begin
         if (per_i == '0) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
         end else if (at_end) begin
            cnt_q  <= '0;
            tick_q <= 1'b1;
         end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_q <= 1'b0;
         end
      end else begin
         tick_q <= 1'b0;
      end
   end

   assign tick_o = tick_q;
   assign cnt_o  = cnt_q;
endmodule

// File: rtl/mstick_timer.sv
module mstick_timer #(
   parameter int CYC_PER_MS = mstick_pkg::DEF_CYC_PER_MS,
   parameter int PERIOD_W   = mstick_pkg::DEF_PERIOD_W,
   parameter int MAX_PERIOD = mstick_pkg::DEF_MAX_PERIOD,
   parameter int RST_PERIOD = 0
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                load_i,
   input  logic [PERIOD_W-1:0] period_i,
   output logic                tick_o
);
   localparam int PRE_W = $clog2(CYC_PER_MS);

   generate
      if (CYC_PER_MS < 2) begin : g_bad_cyc
         $error("CYC_PER_MS must be at least 2");
      end
      if (MAX_PERIOD < 1 || MAX_PERIOD > (1 << PERIOD_W) - 1) begin : g_bad_max
         $error("MAX_PERIOD must fit in PERIOD_W and be nonzero");
      end
      if (RST_PERIOD < 0 || RST_PERIOD > MAX_PERIOD) begin : g_bad_rst
         $error("RST_PERIOD must lie within 0..MAX_PERIOD");
      end
   endgenerate

   logic                ms_stb;
   logic [PRE_W-1:0]    pre_cnt;
   logic [PERIOD_W-1:0] per_q;
   logic [PERIOD_W-1:0] ms_cnt;

   mstick_period_reg #(
      .PERIOD_W  (PERIOD_W),
      .MAX_PERIOD(MAX_PERIOD),
      .RST_PERIOD(RST_PERIOD)
   ) u_per (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(load_i),
      .din_i (period_i),
      .per_o (per_q)
   );

   mstick_prescale #(
      .CYC_PER_MS(CYC_PER_MS)
   ) u_pre (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .restart_i(load_i),
      .ms_stb_o (ms_stb),
      .cnt_o    (pre_cnt)
   );

   mstick_ms_count #(
      .PERIOD_W(PERIOD_W)
   ) u_ms (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .restart_i(load_i),
      .ms_stb_i (ms_stb),
      .per_i    (per_q),
      .tick_o   (tick_o),
      .cnt_o    (ms_cnt)
   );
endmodule

// File: rtl/mstick_timer_chk.sv
module mstick_timer_chk #(
   parameter int CYC_PER_MS = 24000,
   parameter int PERIOD_W   = 8,
   parameter int MAX_PERIOD = 250,
   localparam int PRE_W     = $clog2(CYC_PER_MS)
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic                load_i,
   input logic                tick_o,
   input logic                ms_stb,
   input logic [PRE_W-1:0]    pre_cnt,
   input logic [PERIOD_W-1:0] per_q,
   input logic [PERIOD_W-1:0] ms_cnt
);
   // R2
   tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);

   // R3
   tick_on_ms_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(tick_o) |-> $past(ms_stb));

   // R4
   pre_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pre_cnt <= PRE_W'(CYC_PER_MS - 1));

   // R5
   off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (per_q == '0) |=> !tick_o);

   // R6
   per_ceiling_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      per_q <= PERIOD_W'(MAX_PERIOD));

   // R7
   load_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> (!tick_o && pre_cnt == '0 && ms_cnt == '0));

   // R3
   ms_below_per_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (per_q != '0 && !load_i) |=> (ms_cnt < per_q || $past(per_q) != per_q));
endmodule

bind mstick_timer mstick_timer_chk #(
   .CYC_PER_MS(CYC_PER_MS),
   .PERIOD_W  (PERIOD_W),
   .MAX_PERIOD(MAX_PERIOD)
) chk_i (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .load_i (load_i),
   .tick_o (tick_o),
   .ms_stb (ms_stb),
   .pre_cnt(pre_cnt),
   .per_q  (per_q),
   .ms_cnt (ms_cnt)
);

// File: tb/mstick_timer_tb_top.sv
module mstick_timer_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int N          = 5;
   localparam int W          = 8;
   localparam int CEIL       = 250;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         load = 1'b0;
   logic [W-1:0] per_in = '0;
   logic         tick;

   int checks = 0;
   int errors = 0;
   int t      = 0;
   int P      = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mstick_timer #(
      .CYC_PER_MS(N),
      .PERIOD_W  (W),
      .MAX_PERIOD(CEIL),
      .RST_PERIOD(0)
   ) dut_i (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .load_i  (load),
      .period_i(per_in),
      .tick_o  (tick)
   );

   function automatic int clamp_ref(int v);
      return (v > CEIL) ? CEIL : v;
   endfunction

   function automatic bit tick_ref(int per, int tt);
      if (per == 0 || tt == 0) return 1'b0;
      return (tt % (per * N)) == 0;
   endfunction

   task automatic check(bit act, bit exp, string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s t=%0d P=%0d actual=%0b expected=%0b", req, t, P, act, exp);
      end
   endtask

   // Called at a falling edge; drives inputs, crosses one rising edge, checks.
   task automatic step(bit ld, int val, bit scramble, string req);
      load   = ld;
      per_in = ld ? W'(val) : (scramble ? W'($urandom) : per_in);
      @(posedge clk);
      @(negedge clk);
      if (ld) begin
         t = 0;
         P = clamp_ref(val);
      end else begin
         t++;
      end
      load = 1'b0;
      check(tick, tick_ref(P, t), req);
   endtask

   task automatic run(int cycles, string req);
      for (int i = 0; i < cycles; i++) step(1'b0, 0, 1'b1, req);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      // R1: output low during and after reset, pulses off until a load
      check(tick, 1'b0, "R1");
      rst_n = 1'b1;
      t = 0;
      P = 0;
      run(60, "R1");

      // R4: period 1 gives a pulse every N cycles
      step(1'b1, 1, 1'b0, "R4");
      run(6 * N, "R4");

      // R8: period 3 timed from the load edge, data bus scrambled between loads
      step(1'b1, 3, 1'b0, "R8");
      run(4 * 3 * N + 2, "R8");

      // R2 / R3: period 2, several pulses
      step(1'b1, 2, 1'b0, "R3");
      run(5 * 2 * N, "R2");

      // R7: reload exactly on the edge where a pulse is due
      step(1'b1, 2, 1'b0, "R7");
      run(2 * N - 1, "R7");
      step(1'b1, 2, 1'b0, "R7");
      run(3 * 2 * N, "R7");

      // R7: back-to-back loads and a mid-period reload
      step(1'b1, 4, 1'b0, "R7");
      step(1'b1, 4, 1'b0, "R7");
      run(7, "R7");
      step(1'b1, 1, 1'b0, "R7");
      run(3 * N, "R7");

      // R5: period 0 silences output
      step(1'b1, 0, 1'b0, "R5");
      run(20 * N, "R5");

      // R6: clamp of 255 and 251, exact 250 unchanged
      step(1'b1, 255, 1'b0, "R6");
      run(2 * CEIL * N + 3, "R6");
      step(1'b1, 251, 1'b0, "R6");
      run(CEIL * N + 3, "R6");
      step(1'b1, 250, 1'b0, "R6");
      run(CEIL * N + 3, "R6");

      // Random mix: small periods, zero, clamp region, random reload points
      for (int k = 0; k < 150; k++) begin
         int sel = int'($urandom_range(0, 19));
         int v;
         int len;
         if (sel == 0)      v = int'($urandom_range(251, 255));
         else if (sel < 3)  v = 0;
         else               v = int'($urandom_range(1, 12));
         step(1'b1, v, 1'b0, "R3");
         len = (v == 0) ? 30 : int'($urandom_range(1, 3 * clamp_ref(v) * N + 2));
         if (len > 1500) len = 1500;
         run(len, "R3");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule